// File: doc/BRIEF.md
# Eight-Bit Arithmetic/Logic Unit with Status Byte

This block is the datapath arithmetic stage of a small eight-bit processor. An operation select picks one of eight functions: add with carry, subtract with borrow, AND, logical shift right, compare, bit test, increment and decrement. The function works on an accumulator-side operand and a memory-side operand. The result and the proposed next flags come out combinationally, in the same cycle.

The block keeps its own registered eight-bit status byte. Its bit layout, from bit 7 down to bit 0, is N, V, unused, B, D, I, Z, C. The current status feeds the carry input and supplies the flags that an operation leaves alone.

A flag-write strobe commits the proposed flags on the next rising clock edge. Two separate carry commands force the carry bit to 1 or to 0. The commands act whether or not the strobe is high. Instruction decode, memory access, decimal arithmetic and interrupt handling belong to the surrounding core.

Top module: `alu8_flags_unit`

## Requirements
- R1: While `rst_n` is low and after its release, before any write, `status_o` reads 0x20. Bit 5, the unused bit, is then the only bit set.
- R2: With op 0 (add), `result_o` is the low byte of A + M + C, where C is `status_o[0]`. The proposed carry is 1 exactly when that sum exceeds 255.
- R3: With op 1 (subtract), `result_o` is A − M − (1 − C) modulo 256. The proposed carry is 1 when no borrow occurs, that is, when A − M − (1 − C) ≥ 0.
- R4: For add and subtract, the proposed V (bit 6) is 1 when the two effective operands share bit 7 and result bit 7 differs from it. For subtract, the effective second operand is the inverse of M. In every other case V is 0.
- R5: For add, subtract, AND (op 2), shift (op 3), increment (op 6) and decrement (op 7), the proposed Z (bit 1) is 1 exactly when `result_o` is 0x00. The proposed N (bit 7) equals `result_o[7]`.
- R6: With op 4 (compare), `result_o` equals A unchanged. The proposed C is (A ≥ M) and the proposed Z is (A == M). The proposed N is bit 7 of (A − M) modulo 256.
- R7: With op 5 (bit test), `result_o` equals A. The proposed Z is ((A & M) == 0), V equals M[6] and N equals M[7].
- R8: With op 3, `result_o` is A shifted right by one with a 0 entering bit 7. The proposed C is A[0].
- R9: Increment gives A + 1 modulo 256 and decrement gives A − 1 modulo 256. So 0xFF increments to 0x00, and 0x00 decrements to 0xFF.
- R10: An operation leaves unchanged each flag it does not name above. B, D and I never change. Bit 5 of `flags_nxt_o` and of `status_o` is always 1.
- R11: With `flag_we_i` low and both carry commands low, `status_o` keeps its value across the clock edge. With `flag_we_i` high, `status_o` takes the value of `flags_nxt_o` at that edge.
- R12: `carry_set_i` forces `status_o[0]` to 1 at the next edge and `carry_clr_i` forces it to 0. Set wins when both are high. Either command overrides the carry of a concurrent flag write, while the other written flags still land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation select (0 add, 1 sub, 2 and, 3 shift right, 4 compare, 5 bit test, 6 inc, 7 dec) |
| a_i | input | 8 | Accumulator-side operand |
| m_i | input | 8 | Memory-side operand |
| flag_we_i | input | 1 | Commit proposed flags at the next edge |
| carry_set_i | input | 1 | Force carry to 1 at the next edge |
| carry_clr_i | input | 1 | Force carry to 0 at the next edge |
| result_o | output | 8 | Combinational operation result |
| flags_nxt_o | output | 8 | Combinational proposed status byte |
| status_o | output | 8 | Registered status byte |

## Verification
A flag write and a carry command can land on the same edge. The command must then own bit 0 while N, V and Z still come from the operation. The random stimulus raises the carry commands at a low rate while the strobe is often high, so the two overlap regularly. Directed steps pair a carry-producing add with a clear command, and assert set and clear together during a write. Each edge is judged by comparing `status_o` one cycle later with a bench model that merges the op flags and the forced carry in that order.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_I = 2;
    localparam int FL_D = 3;
    localparam int FL_B = 4;
    localparam int FL_U = 5;
    localparam int FL_V = 6;
    localparam int FL_N = 7;
    localparam int MSB  = DATA_W - 1;
    localparam logic [DATA_W-1:0] STATUS_RST = 8'h20;

    typedef enum logic [2:0] {
        OP_ADC = 3'd0,
        OP_SBC = 3'd1,
        OP_AND = 3'd2,
        OP_LSR = 3'd3,
        OP_CMP = 3'd4,
        OP_BIT = 3'd5,
        OP_INC = 3'd6,
        OP_DEC = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] flags;
    } alu_out_t;

    typedef struct packed {
        logic [DATA_W-1:0] status;
    } stat_reg_t;
endpackage

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] m_i,
    input  logic [DATA_W-1:0] st_i,
    output logic [DATA_W-1:0] res_o,
    output logic [DATA_W-1:0] flags_o
);
    alu_out_t          out_d;
    logic [DATA_W-1:0] addend;
    logic              cin;
    logic [DATA_W:0]   sum;
    logic              upd_zn;

    // shared adder: add, subtract, compare, increment, decrement
    always_comb begin
        addend = m_i;
        cin    = st_i[FL_C];
        unique case (op_i)
            OP_SBC:  begin addend = ~m_i; cin = st_i[FL_C]; end
            OP_CMP:  begin addend = ~m_i; cin = 1'b1;       end
            OP_INC:  begin addend = '0;   cin = 1'b1;       end
            OP_DEC:  begin addend = '1;   cin = 1'b0;       end
            default: begin addend = m_i;  cin = st_i[FL_C]; end
        endcase
        sum = {1'b0, a_i} + {1'b0, addend} + {{DATA_W{1'b0}}, cin};
    end

    always_comb begin
        out_d.flags = st_i;
        out_d.res   = a_i;
        upd_zn      = 1'b1;
        unique case (op_i)
            OP_ADC, OP_SBC: begin
                out_d.res         = sum[MSB:0];
                out_d.flags[FL_C] = sum[DATA_W];
                out_d.flags[FL_V] = (a_i[MSB] == addend[MSB]) &&
                                    (sum[MSB] != a_i[MSB]);
            end
            OP_AND: out_d.res = a_i & m_i;
            OP_LSR: begin
                out_d.res         = {1'b0, a_i[MSB:1]};
                out_d.flags[FL_C] = a_i[0];
            end
            OP_CMP: begin
                upd_zn            = 1'b0;
                out_d.res         = a_i;
                out_d.flags[FL_C] = sum[DATA_W];
                out_d.flags[FL_Z] = (sum[MSB:0] == '0);
                out_d.flags[FL_N] = sum[MSB];
            end
            OP_BIT: begin
                upd_zn            = 1'b0;
                out_d.res         = a_i;
                out_d.flags[FL_Z] = ((a_i & m_i) == '0);
                out_d.flags[FL_V] = m_i[6];
                out_d.flags[FL_N] = m_i[MSB];
            end
            default: out_d.res = sum[MSB:0];
        endcase
        if (upd_zn) begin
            out_d.flags[FL_Z] = (out_d.res == '0);
            out_d.flags[FL_N] = out_d.res[MSB];
        end
        out_d.flags[FL_U] = 1'b1;
    end

    assign res_o   = out_d.res;
    assign flags_o = out_d.flags;
endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] flags_i,
    input  logic              we_i,
    input  logic              cset_i,
    input  logic              cclr_i,
    output logic [DATA_W-1:0] status_o
);
    stat_reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.status = flags_i;
        if (cset_i)      st_d.status[FL_C] = 1'b1;
        else if (cclr_i) st_d.status[FL_C] = 1'b0;
        st_d.status[FL_U] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.status <= STATUS_RST;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;

    p_unused_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.status[FL_U]);
    p_carry_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cset_i |=> st_q.status[FL_C]);
    p_carry_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cclr_i && !cset_i) |=> !st_q.status[FL_C]);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && !cset_i && !cclr_i) |=> $stable(st_q.status));
endmodule

// File: rtl/alu8_flags_unit.sv
module alu8_flags_unit
    import alu8_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  op_i,
    input  logic [7:0]  a_i,
    input  logic [7:0]  m_i,
    input  logic        flag_we_i,
    input  logic        carry_set_i,
    input  logic        carry_clr_i,
    output logic [7:0]  result_o,
    output logic [7:0]  flags_nxt_o,
    output logic [7:0]  status_o
);
    alu_op_e op;
    assign op = alu_op_e'(op_i);

    alu8_core u_core (
        .op_i    (op),
        .a_i     (a_i),
        .m_i     (m_i),
        .st_i    (status_o),
        .res_o   (result_o),
        .flags_o (flags_nxt_o)
    );

    alu8_status_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags_i  (flags_nxt_o),
        .we_i     (flag_we_i),
        .cset_i   (carry_set_i),
        .cclr_i   (carry_clr_i),
        .status_o (status_o)
    );

    // AND leaves carry and overflow untouched
    p_and_keeps_cv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i == 3'd2 && !carry_set_i && !carry_clr_i)
        |=> (status_o[FL_C] == $past(status_o[FL_C])) &&
            (status_o[FL_V] == $past(status_o[FL_V])));
    // write lands the proposed byte
    p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && !carry_set_i && !carry_clr_i)
        |=> status_o == $past(flags_nxt_o));
    // B, D and I never move
    p_bdi_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[4:2] == 3'b000);
endmodule

// File: tb/tb_alu8_flags_unit.sv
module tb_alu8_flags_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_i = '0;
    logic [7:0] a_i = '0, m_i = '0;
    logic       flag_we_i = 1'b0, carry_set_i = 1'b0, carry_clr_i = 1'b0;
    logic [7:0] result_o, flags_nxt_o, status_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] exp_st;

    always #2.5 clk = ~clk;

    alu8_flags_unit dut (.*);

    // independent model: returns {result, proposed flags}
    function automatic logic [15:0] model(input logic [2:0] op, input logic [7:0] a,
                                          input logic [7:0] m, input logic [7:0] st);
        logic [7:0] r, f;
        int t;
        bit zn;
        f = st; r = a; zn = 1;
        case (op)
            3'd0: begin
                t = int'(a) + int'(m) + int'(st[0]);
                r = t[7:0]; f[0] = (t > 255);
                f[6] = (a[7] == m[7]) && (r[7] != a[7]);
            end
            3'd1: begin
                t = int'(a) - int'(m) - (1 - int'(st[0]));
                r = t[7:0]; f[0] = (t >= 0);
                f[6] = (a[7] != m[7]) && (r[7] != a[7]);
            end
            3'd2: r = a & m;
            3'd3: begin r = a >> 1; f[0] = a[0]; end
            3'd4: begin
                zn = 0; t = int'(a) - int'(m);
                f[0] = (a >= m); f[1] = (a == m); f[7] = t[7];
            end
            3'd5: begin
                zn = 0; f[1] = ((a & m) == 0); f[6] = m[6]; f[7] = m[7];
            end
            3'd6: r = a + 8'd1;
            default: r = a - 8'd1;
        endcase
        if (zn) begin f[1] = (r == 0); f[7] = r[7]; end
        f[5] = 1'b1;
        return {r, f};
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R5";
            3'd3: return "R8";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // one cycle: check last edge, drive, check combinational outputs, advance model
    task automatic step(input string tag, input logic [2:0] op, input logic [7:0] a,
                        input logic [7:0] m, input logic we, input logic cs, input logic cc);
        logic [15:0] e;
        @(negedge clk);
        check({tag, " status (R11/R12)"}, status_o, exp_st);
        op_i = op; a_i = a; m_i = m; flag_we_i = we; carry_set_i = cs; carry_clr_i = cc;
        #1;
        e = model(op, a, m, exp_st);
        check({tag, " result"}, result_o, e[15:8]);
        check({tag, " flags R4 R5 R10"}, flags_nxt_o, e[7:0]);
        if (we) exp_st = e[7:0];
        if (cs)      exp_st[0] = 1'b1;
        else if (cc) exp_st[0] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0A1B);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", status_o, 8'h20);
        rst_n = 1'b1;
        exp_st = 8'h20;
        // directed corners
        step("R2 ff+01",      3'd0, 8'hFF, 8'h01, 1, 0, 0);
        step("R4 7f+00+c",    3'd0, 8'h7F, 8'h00, 1, 0, 0);
        step("R3 00-01 c0",   3'd1, 8'h00, 8'h01, 1, 0, 0);
        step("R4 80-01",      3'd1, 8'h80, 8'h01, 1, 1, 0);
        step("R9 inc ff",     3'd6, 8'hFF, 8'h00, 1, 0, 0);
        step("R9 dec 00",     3'd7, 8'h00, 8'h00, 1, 0, 0);
        step("R7 bit c0/3f",  3'd5, 8'h3F, 8'hC0, 1, 0, 0);
        step("R6 cmp eq",     3'd4, 8'h42, 8'h42, 1, 0, 0);
        step("R6 cmp lt",     3'd4, 8'h10, 8'h20, 1, 0, 0);
        step("R8 lsr 01",     3'd3, 8'h01, 8'h00, 1, 0, 0);
        step("R10 and keeps", 3'd2, 8'hF0, 8'h0F, 1, 0, 0);
        step("R11 no write",  3'd0, 8'h80, 8'h80, 0, 0, 0);
        step("R12 add+clr",   3'd0, 8'hFF, 8'hFF, 1, 0, 1);
        step("R12 set+clr",   3'd1, 8'h05, 8'h03, 1, 1, 1);
        step("R12 clr only",  3'd2, 8'h00, 8'h00, 0, 0, 1);
        step("R12 set no we", 3'd3, 8'h02, 8'h00, 0, 1, 0);
        step("R1 idle",       3'd2, 8'h00, 8'h00, 0, 0, 0);
        // random mix, carry commands at a low rate
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            step(req_of(op), op, 8'($urandom), 8'($urandom),
                 ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0),
                 ($urandom_range(0, 7) == 0));
        end
        @(negedge clk);
        check("R11 final status", status_o, exp_st);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule